// File: doc/BRIEF.md
# Block-Partitioned Trial Key Counter

This block produces the sequence of trial keys for one brute-force key search unit. The key space is cut into blocks: a block number handed in from outside sits in the upper key bits and stays fixed, while a local binary counter sweeps the lower bits from zero up to all ones. The controller of the search machine hands a unit a block, waits for the unit to report that the block is exhausted, and then hands it the next one.

The unit's cipher may need several cycles per key, so an inhibit input can freeze the counter. When the comparator flags a possible match, a halt input freezes the key until the controller orders a restart. Only the low counter bits are given back for readback, since the controller already knows which block each unit holds. A second copy of those bits, delayed by a fixed number of cycles, lines up the key with a comparator result that arrives later through the cipher pipeline.

By default the key is 80 bits wide: a 48-bit block field above a 32-bit counting field. The bench uses narrower fields so that it can run a whole block.

Top module: `trial_key_counter`

## Requirements
- R1: `trial_key` is the block field (BLK_W bits, upper) concatenated above the low field (CNT_W bits, lower), and `key_low` equals the low field. The block field changes only in the cycle after `blk_load`, and after reset it is zero.
- R2: One cycle after `blk_load`, the block field equals the `blk_num` that was presented, the low field is zero, `end_of_block` is low, and the unit is counting. A load in the same cycle as halt, restart or inhibit, or while the unit is halted or finished, still takes effect.
- R3: While counting, and not inhibited or halted, the low field rises by exactly one on each clock.
- R4: While `inhibit` is high, the low field holds its value.
- R5: When the low field is all ones and would advance, it stays all ones and `end_of_block` goes high on the next cycle. The all-ones key is therefore issued for at least one cycle before the flag.
- R6: Once set, `end_of_block` stays high and the low field stays frozen, and `restart` and `match_halt` have no effect, until the next `blk_load`.
- R7: A `match_halt` while counting freezes the key from the next cycle on, whatever `inhibit` does, until `restart`. In the `restart` cycle the key still holds. Counting resumes one cycle after that.
- R8: `key_low_dly` equals the value `key_low` had LAT cycles earlier. It reads zero during the first LAT cycles after reset.
- R9: After reset the unit is idle: key zero, `end_of_block` low, no counting. `match_halt` is ignored while idle. `restart` while idle starts counting in block zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_load | input | 1 | Load `blk_num` and start the block from zero |
| blk_num | input | BLK_W | Block number for the upper key bits |
| restart | input | 1 | Resume after a halt, or start from idle |
| inhibit | input | 1 | Freeze the counter for this cycle |
| match_halt | input | 1 | Possible match flagged: hold the key |
| trial_key | output | BLK_W+CNT_W | Current trial key |
| end_of_block | output | 1 | Sticky flag: low field exhausted |
| key_low | output | CNT_W | Low key bits for readback |
| key_low_dly | output | CNT_W | `key_low` delayed by LAT cycles |

## Verification
The bench goes after the last step of a block. A counter that wraps to zero, raises the flag a cycle early, or skips issuing the all-ones key breaks the low-field and flag comparison around that point. It applies restart and halt pulses after the block is finished and while the unit is idle, which shows a design that lets either control wake the counter. It presents a load in the same cycle as halt and inhibit, and while the unit is halted, which catches a priority order that lets the hold win. It toggles inhibit during a halt, which exposes a design that resumes counting on an inhibit release rather than on restart. The delayed readback is compared on every cycle, so a delay line that is one stage short or long shows up at once.

// File: rtl/tkc_pkg.sv
package tkc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2,
    ST_DONE = 2'd3
  } tkc_state_e;
endpackage

// File: rtl/tkc_seq.sv
module tkc_seq
  import tkc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       restart,
  input  logic       inhibit,
  input  logic       match_halt,
  input  logic       at_max,
  output logic       cnt_clr,
  output logic       cnt_inc,
  output logic       eob,
  output tkc_state_e state
);
  tkc_state_e state_d, state_q;

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (load) begin
      cnt_clr = 1'b1;
      state_d = ST_RUN;
    end else begin
      case (state_q)
        ST_IDLE: if (restart) state_d = ST_RUN;
        ST_RUN: begin
          if (match_halt) state_d = ST_HALT;
          else if (!inhibit) begin
            if (at_max) state_d = ST_DONE;
            else        cnt_inc = 1'b1;
          end
        end
        ST_HALT: if (restart) state_d = ST_RUN;
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      eob     <= 1'b0;
    end else begin
      state_q <= state_d;
      eob     <= (state_d == ST_DONE);
    end
  end

  assign state = state_q;
endmodule

// File: rtl/tkc_lowcnt.sv
module tkc_lowcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + ONE;
  end

  assign at_max = &cnt;
endmodule

// File: rtl/tkc_blkreg.sv
module tkc_blkreg #(
  parameter int BLK_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] blk
);
  always_ff @(posedge clk) begin
    if (rst)     blk <= '0;
    else if (we) blk <= din;
  end
endmodule

// File: rtl/tkc_delay.sv
module tkc_delay #(
  parameter int W   = 32,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (LAT == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] stg [LAT];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < LAT; i++) stg[i] <= '0;
        end else begin
          stg[0] <= din;
          for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
        end
      end
      assign dout = stg[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/trial_key_counter.sv
module trial_key_counter
  import tkc_pkg::*;
#(
  parameter int BLK_W = 48,
  parameter int CNT_W = 32,
  parameter int LAT   = 4,
  localparam int KEY_W = BLK_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_load,
  input  logic [BLK_W-1:0] blk_num,
  input  logic             restart,
  input  logic             inhibit,
  input  logic             match_halt,
  output logic [KEY_W-1:0] trial_key,
  output logic             end_of_block,
  output logic [CNT_W-1:0] key_low,
  output logic [CNT_W-1:0] key_low_dly
);
  logic             cnt_clr, cnt_inc, at_max;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] blk;
  tkc_state_e       st;

  tkc_seq u_seq (
    .clk(clk), .rst(rst), .load(blk_load), .restart(restart),
    .inhibit(inhibit), .match_halt(match_halt), .at_max(at_max),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .eob(end_of_block), .state(st)
  );

  tkc_lowcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .cnt(cnt), .at_max(at_max)
  );

  tkc_blkreg #(.BLK_W(BLK_W)) u_blk (
    .clk(clk), .rst(rst), .we(blk_load), .din(blk_num), .blk(blk)
  );

  tkc_delay #(.W(CNT_W), .LAT(LAT)) u_dly (
    .clk(clk), .rst(rst), .din(cnt), .dout(key_low_dly)
  );

  assign trial_key = {blk, cnt};
  assign key_low   = cnt;
endmodule

// File: rtl/tkc_chk.sv
module tkc_chk
  import tkc_pkg::*;
#(
  parameter int BLK_W = 48,
  parameter int CNT_W = 32,
  localparam int KEY_W = BLK_W + CNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             blk_load,
  input logic [BLK_W-1:0] blk_num,
  input logic             inhibit,
  input logic [KEY_W-1:0] trial_key,
  input logic [CNT_W-1:0] key_low,
  input logic             end_of_block,
  input logic [1:0]       st_code
);
  AST_BLK_HELD: assert property (@(posedge clk) disable iff (rst)
    !blk_load |=> $stable(trial_key[KEY_W-1 -: BLK_W])); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    blk_load |=> (key_low == '0) && !end_of_block &&
                 (trial_key[KEY_W-1 -: BLK_W] == $past(blk_num))); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !blk_load |=> (key_low == $past(key_low)) ||
                  (key_low == CNT_W'($past(key_low) + 1'b1))); // R3
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !blk_load) |=> $stable(key_low)); // R4
  AST_EOB_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    $rose(end_of_block) |-> (&key_low)); // R5
  AST_EOB_STICKY: assert property (@(posedge clk) disable iff (rst)
    (end_of_block && !blk_load) |=> end_of_block && $stable(key_low)); // R6
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_code == ST_HALT && !blk_load) |=> $stable(key_low)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_code == ST_IDLE) |=> $stable(key_low)); // R9
endmodule

bind trial_key_counter tkc_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .blk_load(blk_load), .blk_num(blk_num),
  .inhibit(inhibit), .trial_key(trial_key), .key_low(key_low),
  .end_of_block(end_of_block), .st_code(st)
);

// File: tb/trial_key_counter_tb.sv
module trial_key_counter_tb;
  localparam int BLK_W = 12;
  localparam int CNT_W = 6;
  localparam int LAT   = 3;
  localparam int KEY_W = BLK_W + CNT_W;
  localparam longint MAXV = (64'd1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blk_load = 1'b0, restart = 1'b0, inhibit = 1'b0, match_halt = 1'b0;
  logic [BLK_W-1:0] blk_num = '0;
  logic [KEY_W-1:0] trial_key;
  logic end_of_block;
  logic [CNT_W-1:0] key_low, key_low_dly;

  always #5 clk = ~clk;

  trial_key_counter #(.BLK_W(BLK_W), .CNT_W(CNT_W), .LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .blk_load(blk_load), .blk_num(blk_num),
    .restart(restart), .inhibit(inhibit), .match_halt(match_halt),
    .trial_key(trial_key), .end_of_block(end_of_block),
    .key_low(key_low), .key_low_dly(key_low_dly)
  );

  // behavioural reference: 0 idle, 1 counting, 2 held on match, 3 finished
  longint mblk, mcnt;
  int     mst;
  bit     meob, started, finished;
  longint hist[$];
  int     nchk = 0, nfail = 0;
  string  phase = "R9 reset";

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      mblk = 0; mcnt = 0; mst = 0; meob = 0;
      hist.delete();
      for (int i = 0; i < LAT; i++) hist.push_back(0);
    end else begin
      hist.push_back(mcnt);
      void'(hist.pop_front());
      if (blk_load) begin
        mblk = longint'(blk_num); mcnt = 0; mst = 1;
      end else begin
        case (mst)
          0: if (restart) mst = 1;
          1: if (match_halt) mst = 2;
             else if (!inhibit) begin
               if (mcnt == MAXV) mst = 3; else mcnt = mcnt + 1;
             end
          2: if (restart) mst = 1;
          default: mst = 3;
        endcase
      end
      meob = (mst == 3);
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s [%s] act=%0h exp=%0h", tag, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(longint'(trial_key[KEY_W-1 -: BLK_W]) == mblk, "R1 block field",
          longint'(trial_key[KEY_W-1 -: BLK_W]), mblk);
      chk(longint'(trial_key[CNT_W-1:0]) == mcnt && longint'(key_low) == mcnt,
          "R3 low field", longint'(key_low), mcnt);
      chk(end_of_block == meob, "R5 end_of_block",
          longint'(end_of_block), longint'(meob));
      chk(longint'(key_low_dly) == hist[0], "R8 delayed low",
          longint'(key_low_dly), hist[0]);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    blk_load = 0; restart = 0; match_halt = 0; inhibit = 0;
  endtask

  task automatic pulse_load(logic [BLK_W-1:0] b);
    @(negedge clk);
    blk_load = 1; blk_num = b;
    @(negedge clk);
    blk_load = 0;
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
  endtask

  task automatic pulse_halt();
    @(negedge clk); match_halt = 1;
    @(negedge clk); match_halt = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    phase = "R9 idle after reset";
    pulse_halt();
    idle(5);
    phase = "R9 restart from idle";
    pulse_restart();
    idle(5);
    phase = "R2 load and R3 count";
    pulse_load(12'hABC);
    idle(8);
    phase = "R4 inhibit";
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); inhibit = (i % 3) != 0;
    end
    idle(2);
    phase = "R7 halt held";
    pulse_halt();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); inhibit = i[0];
    end
    @(negedge clk); inhibit = 0;
    phase = "R7 restart";
    pulse_restart();
    idle(4);
    phase = "R2 load beats halt and inhibit";
    @(negedge clk);
    blk_load = 1; blk_num = 12'h35C; match_halt = 1; inhibit = 1;
    @(negedge clk);
    blk_load = 0; match_halt = 0; inhibit = 0;
    idle(3);
    phase = "R2 load while halted";
    pulse_halt();
    idle(2);
    pulse_load(12'h7E1);
    phase = "R5 run to end of block";
    idle(75);
    phase = "R6 restart and halt ignored when done";
    pulse_restart();
    pulse_halt();
    @(negedge clk); inhibit = 1;
    idle(4);
    phase = "R6 new block clears flag";
    pulse_load(12'h5A5);
    idle(10);
    phase = "R5 second block with inhibit";
    for (int i = 0; i < 150; i++) begin
      @(negedge clk); inhibit = (i % 4) == 1;
    end
    idle(5);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog expired act=hung exp=done");
      summary();
      $finish;
    end
  end
endmodule